// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 116 level-sensitive interrupt sources and drives one interrupt line to a single CPU. Software runs it through a small 32-bit write/read register bus. A source is enabled, disabled, masked or unmasked by writing its index to a dedicated command register. It is never done by writing a bit mask. Each source has a 4-bit priority held in its own configuration word. The CPU side has a 4-bit threshold, and a source is delivered only when its priority is strictly above that threshold.

A read of the acknowledge register returns the number of the winning source. When priority arbitration is on, the highest priority wins and the lowest index breaks a tie. When it is off, the lowest eligible index wins. If nothing is eligible, the acknowledge register returns the all-ones spurious code. The control register reports how many sources are implemented. A 32-bit doorbell mask word is kept as plain storage.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write of index i (i < 116) to the enable-set register (0x004) enables source i, and a write to the enable-clear register (0x008) disables it. No other source changes.
- R2: A write of index i to the mask-set register (0x010) masks source i, and a write to the mask-clear register (0x014) unmasks it. A masked source is never delivered.
- R3: Source i has a configuration word at 0x400 + 4*i. Its priority sits in bits 27:24 and reads back there. All other bits of the word read as zero.
- R4: The threshold register (0x018) holds a 4-bit value in bits 3:0. A source is eligible only when its priority is strictly greater than the threshold. This holds whether arbitration is on or off.
- R5: The control register (0x000) reads the implemented source count (116) in bits 12:2. Bit 0 is a read/write arbitration-enable bit.
- R6: With arbitration enabled, the acknowledge value is the eligible source with the highest priority. Among equal priorities, the lowest index wins.
- R7: With arbitration disabled, the acknowledge value is the lowest-indexed eligible source, whatever its priority.
- R8: A read of the acknowledge register (0x01C) returns the winning source in bits 9:0, with zeros above. When nothing is eligible it returns 0x3FF. Reading it has no side effect.
- R9: The interrupt output is high exactly when some source is eligible, meaning pending, enabled, unmasked and above the threshold. It follows a change of a source input in the same cycle.
- R10: Writes of an index of 116 or more to any of the four set/clear registers change nothing. This includes values whose low bits alias a real index.
- R11: After reset, all sources are disabled and masked, all priorities and the threshold are 0, arbitration is off, and the doorbell word is 0.
- R12: The doorbell mask register (0x020) is a 32-bit read/write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 12 | Byte address for a read or write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| srcIrq | input | 116 | Level inputs, one per source |
| irqOut | output | 1 | Interrupt line to the CPU |

## Verification
The hardest behaviour to reach from the ports is ordering among several eligible sources. Priority ties, and a source that sits exactly at the threshold, both need many sources set up with chosen priorities and then unmasked one at a time. The stimulus builds that state step by step. After each step it reads the acknowledge register and moves the threshold across the boundary. It also writes out-of-range indices whose low bits alias a live source, so that a truncating decoder would visibly change the winner.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // byte offsets of the register bank
  localparam int OFF_CTL   = 'h000;
  localparam int OFF_ENSET = 'h004;
  localparam int OFF_ENCLR = 'h008;
  localparam int OFF_MSET  = 'h010;
  localparam int OFF_MCLR  = 'h014;
  localparam int OFF_THR   = 'h018;
  localparam int OFF_ACK   = 'h01C;
  localparam int OFF_DB    = 'h020;
  localparam int OFF_CFG   = 'h400;
  // field positions
  localparam int PRIO_SH   = 24;
  localparam int THR_SH    = 0;
  localparam int CNT_LSB   = 2;
  localparam int CNT_W     = 11;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_THR, RD_ACK, RD_DB, RD_CFG
  } rdSel_e;

  typedef struct packed {
    logic   enSet;
    logic   enClr;
    logic   mskSet;
    logic   mskClr;
    logic   ctlWr;
    logic   thrWr;
    logic   dbWr;
    logic   cfgWr;
    logic   idxOk;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 116,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  cfgIdx
);
  localparam int CFG_END = OFF_CFG + 4 * NUM_SRC;

  logic [ADDR_W-1:0] cfgOff;
  logic              cfgHit;

  assign cfgOff = busAddr - ADDR_W'(OFF_CFG);
  assign cfgHit = (busAddr >= ADDR_W'(OFF_CFG)) && (busAddr < ADDR_W'(CFG_END))
                  && (busAddr[1:0] == 2'b00);
  assign cfgIdx = IDX_W'(cfgOff >> 2);

  always_comb begin
    stb       = '0;
    stb.idxOk = busWdata < DATA_W'(NUM_SRC);
    case (busAddr)
      ADDR_W'(OFF_CTL):   begin stb.rdSel = RD_CTL; stb.ctlWr = busWr; end
      ADDR_W'(OFF_ENSET): stb.enSet  = busWr;
      ADDR_W'(OFF_ENCLR): stb.enClr  = busWr;
      ADDR_W'(OFF_MSET):  stb.mskSet = busWr;
      ADDR_W'(OFF_MCLR):  stb.mskClr = busWr;
      ADDR_W'(OFF_THR):   begin stb.rdSel = RD_THR; stb.thrWr = busWr; end
      ADDR_W'(OFF_ACK):   stb.rdSel = RD_ACK;
      ADDR_W'(OFF_DB):    begin stb.rdSel = RD_DB; stb.dbWr = busWr; end
      default: begin
        if (cfgHit) begin
          stb.rdSel = RD_CFG;
          stb.cfgWr = busWr;
        end
      end
    endcase
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 116,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                           arbEn,
  output logic [ID_W-1:0]                ackId,
  output logic                           found
);
  logic [ID_W-1:0]   bestIdx;
  logic [PRIO_W-1:0] bestPrio;

  // linear scan: strict compare keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!found || (arbEn && (prio[i] > bestPrio)))) begin
        found    = 1'b1;
        bestIdx  = ID_W'(i);
        bestPrio = prio[i];
      end
    end
    ackId = found ? bestIdx : '1;
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    found |-> ((ackId < ID_W'(NUM_SRC)) && elig[ackId])); // R6

  AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |-> (ackId == '1)); // R8
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 116,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 10,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  logic [NUM_SRC-1:0]             enReg;
  logic [NUM_SRC-1:0]             mskReg;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioReg;
  logic [PRIO_W-1:0]              thrReg;
  logic                           arbEn;
  logic [DATA_W-1:0]              dbReg;
  logic [NUM_SRC-1:0]             elig;
  logic [IDX_W-1:0]               wIdx;
  logic [ID_W-1:0]                ackId;
  logic                           found;

  assign wIdx = busWdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg   <= '0;
      mskReg  <= '1;
      prioReg <= '0;
      thrReg  <= '0;
      arbEn   <= 1'b0;
      dbReg   <= '0;
    end else begin
      if (stb.idxOk) begin
        if (stb.enSet)  enReg[wIdx]  <= 1'b1;
        if (stb.enClr)  enReg[wIdx]  <= 1'b0;
        if (stb.mskSet) mskReg[wIdx] <= 1'b1;
        if (stb.mskClr) mskReg[wIdx] <= 1'b0;
      end
      if (stb.ctlWr) arbEn  <= busWdata[0];
      if (stb.thrWr) thrReg <= busWdata[THR_SH +: PRIO_W];
      if (stb.cfgWr) prioReg[cfgIdx] <= busWdata[PRIO_SH +: PRIO_W];
      if (stb.dbWr)  dbReg  <= busWdata;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = srcIrq[g] & enReg[g] & ~mskReg[g] & (prioReg[g] > thrReg);
  end

  assign irqOut = |elig;

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .elig  (elig),
    .prio  (prioReg),
    .arbEn (arbEn),
    .ackId (ackId),
    .found (found)
  );

  always_comb begin
    busRdata = '0;
    case (stb.rdSel)
      RD_CTL: begin
        busRdata[CNT_LSB +: CNT_W] = CNT_W'(NUM_SRC);
        busRdata[0]                = arbEn;
      end
      RD_THR: busRdata[THR_SH +: PRIO_W]  = thrReg;
      RD_ACK: busRdata[ID_W-1:0]          = ackId;
      RD_DB:  busRdata                    = dbReg;
      RD_CFG: busRdata[PRIO_SH +: PRIO_W] = prioReg[cfgIdx];
      default: busRdata = '0;
    endcase
  end

  AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (stb.enSet && stb.idxOk) |=> enReg[$past(wIdx)]); // R1

  AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (stb.enClr && stb.idxOk) |=> !enReg[$past(wIdx)]); // R1

  AST_MSKCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (stb.mskClr && stb.idxOk) |=> !mskReg[$past(wIdx)]); // R2

  AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((stb.enSet || stb.enClr || stb.mskSet || stb.mskClr) && !stb.idxOk)
      |=> ($stable(enReg) && $stable(mskReg))); // R10

  AST_IRQ_ACK_AGREE: assert property (@(posedge clk) disable iff (rst)
    irqOut == (ackId != '1)); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 116,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 10,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  strobe_t          stb;
  logic [IDX_W-1:0] cfgIdx;

  pic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb),
    .cfgIdx   (cfgIdx)
  );

  pic_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .cfgIdx   (cfgIdx),
    .busWdata (busWdata),
    .srcIrq   (srcIrq),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int N = 116;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         busWr = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [N-1:0] srcIrq = '0;
  logic         irqOut;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;

  // behavioural reference state
  bit          mEn [N];
  bit          mMsk [N];
  int          mPri [N];
  int          mThr;
  bit          mArb;
  logic [31:0] mDb;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIrq(srcIrq), .irqOut(irqOut)
  );

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin mEn[i] = 0; mMsk[i] = 1; mPri[i] = 0; end
    mThr = 0; mArb = 0; mDb = '0;
  endtask

  function automatic bit modelElig(int i);
    return srcIrq[i] && mEn[i] && !mMsk[i] && (mPri[i] > mThr);
  endfunction

  function automatic int modelAck();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (modelElig(i)) begin
        if (best < 0) best = i;
        else if (mArb && mPri[i] > mPri[best]) best = i;
      end
    return (best < 0) ? 'h3FF : best;
  endfunction

  task automatic modelWrite(int a, logic [31:0] d);
    if (a == 'h000) mArb = d[0];
    else if (a == 'h004 && d < N) mEn[d] = 1;
    else if (a == 'h008 && d < N) mEn[d] = 0;
    else if (a == 'h010 && d < N) mMsk[d] = 1;
    else if (a == 'h014 && d < N) mMsk[d] = 0;
    else if (a == 'h018) mThr = int'(d[3:0]);
    else if (a == 'h020) mDb = d;
    else if (a >= 'h400 && a < 'h400 + 4*N && a % 4 == 0) mPri[(a - 'h400)/4] = int'(d[27:24]);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(int a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = 12'(a); busWdata = d;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readCheck(string req, int a, logic [31:0] exp);
    @(negedge clk);
    busAddr = 12'(a);
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic ackCheck(string req);
    readCheck(req, 'h01C, 32'(modelAck()));
  endtask

  // per-cycle comparison of the interrupt line (R9)
  always begin
    @(posedge clk);
    #3;
    if (running) check("R9 irq", {31'b0, irqOut}, {31'b0, modelAck() != 'h3FF});
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    running = 1'b1;

    // R11 / R5: reset state
    readCheck("R5 R11 ctl", 'h000, 32'(116 << 2));
    readCheck("R11 thr", 'h018, 32'h0);
    readCheck("R11 cfg0", 'h400, 32'h0);
    readCheck("R11 cfg115", 'h400 + 4*115, 32'h0);
    readCheck("R11 db", 'h020, 32'h0);
    readCheck("R8 R11 ack spurious", 'h01C, 32'h3FF);

    srcIrq = '1;
    repeat (2) @(negedge clk);
    check("R11 disabled+masked", {31'b0, irqOut}, 32'h0);

    // R3: priorities, readback limited to bits 27:24
    busWrite('h400 + 4*3,   32'h0200_0000);
    busWrite('h400 + 4*7,   32'h0500_0000);
    busWrite('h400 + 4*50,  32'h0500_0000);
    busWrite('h400 + 4*115, 32'h0900_0000);
    busWrite('h400 + 4*10,  32'hFFFF_FFFF);
    readCheck("R3 cfg10 field only", 'h400 + 4*10, 32'h0F00_0000);
    readCheck("R3 cfg115", 'h400 + 4*115, 32'h0900_0000);

    foreach (mEn[i]) if (i == 3 || i == 7 || i == 50 || i == 115) busWrite('h004, 32'(i));
    check("R2 enabled but masked", {31'b0, irqOut}, 32'h0);

    busWrite('h014, 7);
    ackCheck("R7 single source");
    readCheck("R7 ack=7", 'h01C, 32'd7);
    busWrite('h014, 3);
    readCheck("R7 lowest index wins", 'h01C, 32'd3);

    busWrite('h000, 1);
    readCheck("R5 arb bit", 'h000, 32'(116 << 2) | 32'h1);
    readCheck("R6 highest prio", 'h01C, 32'd7);
    busWrite('h014, 50);
    readCheck("R6 tie lowest index", 'h01C, 32'd7);
    busWrite('h014, 115);
    readCheck("R6 prio 9 wins", 'h01C, 32'd115);

    busWrite('h018, 9);
    readCheck("R4 thr readback", 'h018, 32'd9);
    readCheck("R4 equal not delivered", 'h01C, 32'h3FF);
    busWrite('h018, 8);
    readCheck("R4 above threshold", 'h01C, 32'd115);
    busWrite('h018, 4);

    srcIrq[115] = 1'b0;
    #1;
    check("R9 level drop", {31'b0, irqOut}, 32'h1);
    readCheck("R9 ack after drop", 'h01C, 32'd7);

    busWrite('h008, 7);
    readCheck("R1 clear only source 7", 'h01C, 32'd50);
    busWrite('h010, 50);
    readCheck("R2 mask set", 'h01C, 32'h3FF);
    busWrite('h018, 1);
    readCheck("R4 lowered thr", 'h01C, 32'd3);

    // R10: out-of-range and aliasing indices
    busWrite('h010, 131);
    busWrite('h008, 131);
    busWrite('h010, 116);
    busWrite('h008, 32'hFFFF_FF83);
    readCheck("R10 ignored indices", 'h01C, 32'd3);
    busWrite('h004, 128 + 7);
    readCheck("R10 alias enable ignored", 'h01C, 32'd3);

    busWrite('h000, 0);
    busWrite('h014, 50);
    busWrite('h004, 7);
    readCheck("R7 arb off lowest", 'h01C, 32'd3);
    busWrite('h008, 3);
    readCheck("R1 clear 3", 'h01C, 32'd7);

    // R12 doorbell storage
    busWrite('h020, 32'hFFFF_FFFF);
    readCheck("R12 db ones", 'h020, 32'hFFFF_FFFF);
    busWrite('h020, 32'h1234_5678);
    readCheck("R12 db pattern", 'h020, 32'h1234_5678);
    ackCheck("R8 final ack");

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule